// File: doc/BRIEF.md
# I/O Expander Register Write Target (two-wire serial)

This block is the write side of a two-wire serial target that sits in front of an 8-bit I/O expander. It watches oversampled clock and data lines from the bus and recognises start and stop conditions. It compares the first byte of each transaction against its 7-bit device address. The upper six address bits are fixed, and the lowest address bit comes from a strap input. When the address matches and the transfer direction is write, the target acknowledges. It then takes a command byte that picks one of four registers, and writes every following data byte into that register.

The block has four registers. The input register follows the pin values and cannot be written. The output, polarity and configuration registers are writable. All four are visible on ports. Each update of the output register comes with a one-cycle strobe, so the pin drivers can latch the new value. The block answers on the bus only through a pull-down enable for the data line. That enable is active only while the target acknowledges a byte.

Top module: `ioexp_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal binary 010000 followed by `addr_sel`, and whose least significant bit (R/W) is 0. To acknowledge, it holds the data line low for the whole ninth clock of that byte.
- R2: An address byte that does not match, or that has R/W = 1, is not acknowledged. The rest of that transaction is ignored, and no register changes.
- R3: A command byte from 0x00 to 0x03 is acknowledged. Any other command byte is not acknowledged, and the data bytes that follow it are not acknowledged and change nothing.
- R4: Each data byte after an accepted command is acknowledged. It is written to the register that the command selects: 0x01 selects the output register, 0x02 the polarity register and 0x03 the configuration register.
- R5: Any number of data bytes may follow one command in a single transaction. Every one of them goes to the same selected register, so the last byte is the one that remains.
- R6: Command 0x00 selects the input register. Data bytes sent with this command are acknowledged but change no register. The input register shows `pin_i` one clock later.
- R7: A new output register value appears together with a single-cycle `out_wr_o` pulse. This happens only after the clock falling edge that ends the acknowledge of that data byte. During the acknowledge clock, the previous value is still shown.
- R8: A start or repeated start at any point discards the partial byte and restarts address matching. A stop at any point discards the partial byte and returns the target to idle. In neither case is a partial byte written.
- R9: After reset, the output register is 0xFF, the polarity register is 0x00 and the configuration register is 0xFF, and the data line is released.
- R10: The pull-down enable is asserted only during acknowledge clocks. It rises in the cycle after the sampled clock falls following the eighth bit. It is released after the falling edge that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that sets the lowest device address bit |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| pin_i | input | 8 | Pin levels captured into the input register |
| sda_pull_o | output | 1 | Pull-down enable for the data line |
| in_port_o | output | 8 | Input register |
| out_port_o | output | 8 | Output register |
| pol_o | output | 8 | Polarity inversion register |
| cfg_o | output | 8 | Configuration register |
| out_wr_o | output | 1 | One-cycle strobe when the output register is written |

## Verification
The bench plays the bus master and checks the acknowledge bit on every byte. It also checks each register against its own model after every transaction.

It targets the following corner cases and the failure each one would expose:
- A wrong or read-direction address. A design that acknowledges it, or decodes the strap bit wrongly, would write registers it does not own.
- Out-of-range commands, and writes with command 0x00. A design that decodes only the low command bits would corrupt the output or configuration register.
- A stream of many bytes. A design that moves to the next register would spread the data across registers.
- A repeated start and a stop in the middle of a byte. A design that keeps partial bytes would write garbage.
- The output value sampled during the acknowledge clock. This exposes a design that commits the value too early.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [5:0]        ADDR_BASE = 6'b010000;
    localparam logic [BYTE_W-1:0] RST_OUT   = 8'hFF;
    localparam logic [BYTE_W-1:0] RST_POL   = 8'h00;
    localparam logic [BYTE_W-1:0] RST_CFG   = 8'hFF;

    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_CFG = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic strap);
        return (b[7:1] == {ADDR_BASE, strap}) && !b[0];
    endfunction

    function automatic logic cmd_ok(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:2] == '0;
    endfunction

endpackage

// File: rtl/ioexp_line_sampler.sv
module ioexp_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_s, sda_s;
    logic              scl_d, sda_d, scl_lvl;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                scl_s[g] <= 1'b1;
                sda_s[g] <= 1'b1;
            end else if (g == 0) begin
                scl_s[g] <= scl_raw;
                sda_s[g] <= sda_raw;
            end else begin
                scl_s[g] <= scl_s[(g == 0) ? 0 : g-1];
                sda_s[g] <= sda_s[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_lvl = scl_s[STAGES-1];
    assign sda_lvl = sda_s[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_lvl;
            sda_d <= sda_lvl;
        end
    end

    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;
    assign start_ev = scl_lvl & scl_d & ~sda_lvl & sda_d;
    assign stop_ev  = scl_lvl & scl_d & sda_lvl & ~sda_d;
endmodule

// File: rtl/ioexp_byte_fsm.sv
module ioexp_byte_fsm
    import ioexp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    addr_sel,
    input  logic    sda_lvl,
    input  logic    scl_rise,
    input  logic    scl_fall,
    input  logic    start_ev,
    input  logic    stop_ev,
    output logic    sda_pull,
    output wr_req_t wr
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    phase_e            phase_q;
    logic [CNT_W-1:0]  bit_q;
    logic              in_ack_q, ack_q;
    logic [BYTE_W-1:0] shreg_q;
    reg_sel_e          sel_q;
    logic              ack_ok;

    always_comb begin
        case (phase_q)
            PH_ADDR: ack_ok = addr_hit(shreg_q, addr_sel);
            PH_CMD:  ack_ok = cmd_ok(shreg_q);
            PH_DATA: ack_ok = 1'b1;
            default: ack_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            in_ack_q <= 1'b0;
            ack_q    <= 1'b0;
            shreg_q  <= '0;
            sel_q    <= SEL_IN;
        end else if (start_ev) begin
            phase_q  <= PH_ADDR;
            bit_q    <= '0;
            in_ack_q <= 1'b0;
            ack_q    <= 1'b0;
        end else if (stop_ev) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            in_ack_q <= 1'b0;
            ack_q    <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (scl_rise && !in_ack_q && bit_q < LAST_BIT) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                bit_q   <= bit_q + 1'b1;
            end else if (scl_fall && !in_ack_q && bit_q == LAST_BIT) begin
                in_ack_q <= 1'b1;
                ack_q    <= ack_ok;
            end else if (scl_fall && in_ack_q) begin
                in_ack_q <= 1'b0;
                ack_q    <= 1'b0;
                bit_q    <= '0;
                if (!ack_q) begin
                    phase_q <= PH_IDLE;
                end else if (phase_q == PH_ADDR) begin
                    phase_q <= PH_CMD;
                end else if (phase_q == PH_CMD) begin
                    phase_q <= PH_DATA;
                    sel_q   <= reg_sel_e'(shreg_q[1:0]);
                end
            end
        end
    end

    assign sda_pull = ack_q;

    always_comb begin
        wr.en   = scl_fall && in_ack_q && ack_q && (phase_q == PH_DATA) && !start_ev && !stop_ev;
        wr.sel  = sel_q;
        wr.data = shreg_q;
    end

    AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(scl_fall)) else $error("pull not after fall"); // R10
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_pull) else $error("start kept pull"); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> (!sda_pull && !wr.en)) else $error("idle active"); // R2
endmodule

// File: rtl/ioexp_regfile.sv
module ioexp_regfile
    import ioexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] pin_i,
    input  wr_req_t           wr,
    output logic [BYTE_W-1:0] in_q,
    output logic [BYTE_W-1:0] out_q,
    output logic [BYTE_W-1:0] pol_q,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              out_wr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= '0;
            out_q  <= RST_OUT;
            pol_q  <= RST_POL;
            cfg_q  <= RST_CFG;
            out_wr <= 1'b0;
        end else begin
            in_q   <= pin_i;
            out_wr <= 1'b0;
            if (wr.en) begin
                case (wr.sel)
                    SEL_OUT: begin
                        out_q  <= wr.data;
                        out_wr <= 1'b1;
                    end
                    SEL_POL: pol_q <= wr.data;
                    SEL_CFG: cfg_q <= wr.data;
                    default: ;
                endcase
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_wr |=> !out_wr) else $error("strobe too long"); // R7
    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_q == RST_OUT && pol_q == RST_POL && cfg_q == RST_CFG))
        else $error("bad reset values"); // R9
endmodule

// File: rtl/ioexp_i2c_target.sv
module ioexp_i2c_target
    import ioexp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_sel,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [7:0]  pin_i,
    output logic        sda_pull_o,
    output logic [7:0]  in_port_o,
    output logic [7:0]  out_port_o,
    output logic [7:0]  pol_o,
    output logic [7:0]  cfg_o,
    output logic        out_wr_o
);
    logic    sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    wr_req_t wr;

    ioexp_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_raw(scl_i), .sda_raw(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    ioexp_byte_fsm u_fsm (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
        .stop_ev(stop_ev), .sda_pull(sda_pull_o), .wr(wr)
    );

    ioexp_regfile u_regs (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr(wr),
        .in_q(in_port_o), .out_q(out_port_o), .pol_q(pol_o),
        .cfg_q(cfg_o), .out_wr(out_wr_o)
    );

    AST_OUT_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        (out_port_o != $past(out_port_o)) |-> ($past(scl_fall) && out_wr_o))
        else $error("output changed off ack end"); // R7
endmodule

// File: tb/test_ioexp_i2c_target.sv
`timescale 1ns/1ps
module test_ioexp_i2c_target;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_sel = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [7:0] pin_i = 8'h00;
    logic       sda_pull_o, out_wr_o;
    logic [7:0] in_port_o, out_port_o, pol_o, cfg_o;
    wire        bus_sda = m_sda & ~sda_pull_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] mdl_out = 8'hFF, mdl_pol = 8'h00, mdl_cfg = 8'hFF;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    ioexp_i2c_target i_ioexp_i2c_target (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .scl_i(m_scl), .sda_i(bus_sda),
        .pin_i(pin_i), .sda_pull_o(sda_pull_o), .in_port_o(in_port_o),
        .out_port_o(out_port_o), .pol_o(pol_o), .cfg_o(cfg_o), .out_wr_o(out_wr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        chk(req, {31'd0, bus_sda}, {31'd0, !exp_ack});
        chk("R7 output held during ack", {24'd0, out_port_o}, {24'd0, mdl_out});
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic chk_regs(input string req);
        wq(4);
        chk(req, {24'd0, out_port_o}, {24'd0, mdl_out});
        chk(req, {24'd0, pol_o}, {24'd0, mdl_pol});
        chk(req, {24'd0, cfg_o}, {24'd0, mdl_cfg});
        chk("R10 released when idle", {31'd0, sda_pull_o}, 32'd0);
    endtask

    task automatic wr_txn(input logic [7:0] abyte, input logic [7:0] cmd, input int n,
                          input logic [7:0] seed, input bit ack_a, input bit ack_c,
                          input string req);
        i2c_start();
        send_byte(abyte, ack_a, {req, " address ack"});
        send_byte(cmd, ack_a && ack_c, {req, " command ack"});
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            bit         live;
            d    = seed + 8'(i * 8'h11);
            live = ack_a && ack_c;
            if (live && cmd == 8'h01) exp_q.push_back(d);
            send_byte(d, live, {req, " data ack"});
            if (live && cmd == 8'h01) mdl_out = d;
            if (live && cmd == 8'h02) mdl_pol = d;
            if (live && cmd == 8'h03) mdl_cfg = d;
        end
        i2c_stop();
        chk_regs(req);
    endtask

    // scoreboard monitor for output register strobes
    always @(negedge clk) begin
        if (!rst && out_wr_o) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected strobe", 32'd1, 32'd0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R7 strobe value", {24'd0, out_port_o}, {24'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wq(5); rst = 1'b0; wq(3);
        chk("R9 reset out", {24'd0, out_port_o}, 32'hFF);
        chk("R9 reset pol", {24'd0, pol_o}, 32'h00);
        chk("R9 reset cfg", {24'd0, cfg_o}, 32'hFF);
        chk("R9 reset pull", {31'd0, sda_pull_o}, 32'd0);

        wr_txn(8'h40, 8'h01, 1, 8'h5A, 1, 1, "R1 R4 out write");
        wr_txn(8'h40, 8'h02, 3, 8'h11, 1, 1, "R5 pol burst");
        wr_txn(8'h40, 8'h03, 2, 8'h0F, 1, 1, "R4 cfg write");
        wr_txn(8'h40, 8'h01, 8, 8'h07, 1, 1, "R5 long out burst");
        wr_txn(8'h42, 8'h01, 1, 8'hAA, 0, 1, "R2 wrong address");
        wr_txn(8'h41, 8'h01, 1, 8'hAB, 0, 1, "R2 read direction");
        wr_txn(8'h40, 8'h04, 2, 8'h33, 1, 0, "R3 command 04");
        wr_txn(8'h40, 8'h81, 1, 8'h44, 1, 0, "R3 command 81");

        pin_i = 8'h3C;
        wr_txn(8'h40, 8'h00, 2, 8'h77, 1, 1, "R6 input select");
        chk("R6 input follows pins", {24'd0, in_port_o}, 32'h3C);

        addr_sel = 1'b1;
        wr_txn(8'h40, 8'h01, 1, 8'h66, 0, 1, "R1 strap low address rejected");
        wr_txn(8'h42, 8'h01, 1, 8'h96, 1, 1, "R1 strap high address");
        addr_sel = 1'b0;

        // R8 repeated start in the middle of a data byte
        i2c_start();
        send_byte(8'h40, 1, "R8 address");
        send_byte(8'h01, 1, "R8 command");
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_start();
        chk("R8 pull off after restart", {31'd0, sda_pull_o}, 32'd0);
        send_byte(8'h40, 1, "R8 readdress");
        send_byte(8'h02, 1, "R8 command");
        send_byte(8'hC5, 1, "R8 data");
        mdl_pol = 8'hC5;
        i2c_stop();
        chk_regs("R8 partial discarded on restart");

        // R8 stop in the middle of a data byte
        i2c_start();
        send_byte(8'h40, 1, "R8 address");
        send_byte(8'h03, 1, "R8 command");
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        i2c_stop();
        chk_regs("R8 partial discarded on stop");

        wq(20);
        chk("R7 all strobes seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule